// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between the register bus of an SPI controller and its shift engine. It holds a transmit queue, filled by the bus and drained by the engine, and a receive queue, filled by the engine and drained by the bus. It reports both fill levels as counts, a six-bit status word, and seven-bit raw and masked interrupt words. A single interrupt line is the OR of the masked word.

Error sources are sticky: a bus push into a full transmit queue, a bus pop from an empty receive queue, and an engine push into a full receive queue. Each stays set until it is cleared through a write-one-to-clear port, whose bit layout differs from the interrupt layout. Two level sources follow the live queue state: transmit empty, and receive level at or above threshold plus one. A further sticky source fires when the external active-low select is released while the controller runs in target mode. Dropping the controller enable empties both queues, and the receive threshold can only be changed while the controller is disabled.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After a synchronous reset both levels are 0, the mask and threshold are 0, `irq` is 0, the raw word is 7'h01 (only transmit empty) and the status word is 6'h0C.
- R2: Words leave each queue in the order they entered. A pop returns data on the clock edge that accepts it, and each level counts the words held.
- R3: Status bits: bit0 busy (`eng_busy` OR enabled with transmit not empty), bit1 transmit full, bit2 transmit empty, bit3 receive empty, bit4 receive full, and bit5 `eng_tgt_tx_busy` gated by `tgt_mode`.
- R4: When enabled, a bus push into a full transmit queue is dropped, the level stays at DEPTH, and raw bit1 (transmit overflow) is set and stays set.
- R5: When enabled, a bus pop from an empty receive queue returns 0 and sets raw bit2 (receive underflow).
- R6: When enabled, an engine push into a full receive queue is dropped and sets raw bit3 (receive overflow).
- R7: Raw bit4 is 1 exactly when the receive level is at least threshold+1. Raw bit0 is 1 exactly when the transmit queue is empty.
- R8: A threshold write is accepted only while `ctl_en` is 0. Writes made while enabled leave the threshold unchanged.
- R9: Clear word: bit0 clears every sticky source (raw bits 1, 2, 3, 6), bit1 clears raw bit2, bit2 clears raw bit3, and bit3 clears raw bit1. A new event in the same cycle wins over the clear.
- R10: `masked_irq` is `raw_irq` AND `irq_mask`, and `irq` is 1 exactly when `masked_irq` is nonzero.
- R11: While `ctl_en` is 0 both queues are held empty, and pushes and pops from either side have no effect on the levels.
- R12: Raw bit6 is set on a 0-to-1 transition of `sel_n` only while `ctl_en` and `tgt_mode` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; low flushes both queues |
| tgt_mode | input | 1 | Controller runs as target |
| sel_n | input | 1 | External select, active low |
| eng_busy | input | 1 | Shift engine busy |
| eng_tgt_tx_busy | input | 1 | Engine still shifting out in target mode |
| bus_tx_push | input | 1 | Bus write into transmit queue |
| bus_tx_data | input | DW | Transmit word |
| bus_rx_pop | input | 1 | Bus read from receive queue |
| bus_rx_data | output | DW | Received word (0 on underflow) |
| eng_tx_pop | input | 1 | Engine takes a transmit word |
| eng_tx_data | output | DW | Word handed to the engine |
| eng_rx_push | input | 1 | Engine stores a received word |
| eng_rx_data | input | DW | Word from the engine |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 7 | New mask |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 4 | Clear bits |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | $clog2(DEPTH) | New receive threshold |
| tx_level | output | $clog2(DEPTH)+1 | Transmit fill count |
| rx_level | output | $clog2(DEPTH)+1 | Receive fill count |
| status | output | 6 | Status word |
| raw_irq | output | 7 | Unmasked interrupt word |
| masked_irq | output | 7 | Masked interrupt word |
| irq_mask | output | 7 | Current mask |
| rx_thr | output | $clog2(DEPTH) | Current receive threshold |
| irq | output | 1 | Interrupt line |

## Verification
The bench builds the unit with DEPTH=32 and DW=16. With a depth of 32, filling either queue to the brim takes only a short loop, so the full-queue drop paths, the full status bits and the overflow sources all come into play. The threshold is set to 3, so the bench can watch the receive full-level source switch at the fourth word and still go on to fill the queue. A 64-deep build changes only the level and threshold widths, which the parameters derive.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int IRQ_W  = 7;
  localparam int STAT_W = 6;
  localparam int CLR_W  = 4;

  // interrupt word positions (decoded by software)
  localparam int IB_TX_EMPTY = 0;
  localparam int IB_TX_OVF   = 1;
  localparam int IB_RX_UNF   = 2;
  localparam int IB_RX_OVF   = 3;
  localparam int IB_RX_LVL   = 4;
  localparam int IB_SEL_OFF  = 6;

  // clear word positions
  localparam int CB_ALL    = 0;
  localparam int CB_RX_UNF = 1;
  localparam int CB_RX_OVF = 2;
  localparam int CB_TX_OVF = 3;

  typedef struct packed {
    logic tgt_tx_busy;
    logic rx_full;
    logic rx_empty;
    logic tx_empty;
    logic tx_full;
    logic busy;
  } status_t;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign wr_ok = wr_en && !full && !flush;
  assign rd_ok = rd_en && !empty && !flush;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rptr];
    else if (rd_en) rd_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      level <= level + LW'(wr_ok) - LW'(rd_ok);
    end
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctl_en,
  input  logic                      tgt_mode,
  input  logic                      sel_n,
  input  logic                      tx_ovf_ev,
  input  logic                      rx_unf_ev,
  input  logic                      rx_ovf_ev,
  input  logic                      tx_empty,
  input  logic [$clog2(DEPTH):0]    rx_level,
  input  logic                      mask_wr,
  input  logic [IRQ_W-1:0]          mask_wdata,
  input  logic                      clr_wr,
  input  logic [CLR_W-1:0]          clr_wdata,
  input  logic                      thr_wr,
  input  logic [$clog2(DEPTH)-1:0]  thr_wdata,
  output logic [IRQ_W-1:0]          raw_irq,
  output logic [IRQ_W-1:0]          masked_irq,
  output logic [IRQ_W-1:0]          irq_mask,
  output logic [$clog2(DEPTH)-1:0]  rx_thr,
  output logic                      irq
);
  localparam int TW = $clog2(DEPTH);
  localparam int LW = TW + 1;

  logic sel_q;
  logic st_tx_ovf, st_rx_unf, st_rx_ovf, st_sel;
  logic clr_all, sel_rise;

  assign clr_all  = clr_wr && clr_wdata[CB_ALL];
  assign sel_rise = sel_n && !sel_q && ctl_en && tgt_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b1;
      st_tx_ovf <= 1'b0;
      st_rx_unf <= 1'b0;
      st_rx_ovf <= 1'b0;
      st_sel    <= 1'b0;
      irq_mask  <= '0;
      rx_thr    <= '0;
    end else begin
      sel_q <= sel_n;
      if (tx_ovf_ev) st_tx_ovf <= 1'b1;
      else if (clr_all || (clr_wr && clr_wdata[CB_TX_OVF])) st_tx_ovf <= 1'b0;
      if (rx_unf_ev) st_rx_unf <= 1'b1;
      else if (clr_all || (clr_wr && clr_wdata[CB_RX_UNF])) st_rx_unf <= 1'b0;
      if (rx_ovf_ev) st_rx_ovf <= 1'b1;
      else if (clr_all || (clr_wr && clr_wdata[CB_RX_OVF])) st_rx_ovf <= 1'b0;
      if (sel_rise) st_sel <= 1'b1;
      else if (clr_all) st_sel <= 1'b0;
      if (mask_wr) irq_mask <= mask_wdata;
      if (thr_wr && !ctl_en) rx_thr <= thr_wdata;
    end
  end

  always_comb begin
    raw_irq              = '0;
    raw_irq[IB_TX_EMPTY] = tx_empty;
    raw_irq[IB_TX_OVF]   = st_tx_ovf;
    raw_irq[IB_RX_UNF]   = st_rx_unf;
    raw_irq[IB_RX_OVF]   = st_rx_ovf;
    raw_irq[IB_RX_LVL]   = (rx_level >= ({1'b0, rx_thr} + LW'(1)));
    raw_irq[IB_SEL_OFF]  = st_sel;
  end

  assign masked_irq = raw_irq & irq_mask;
  assign irq        = |masked_irq;
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ctl_en,
  input  logic                      tgt_mode,
  input  logic                      sel_n,
  input  logic                      eng_busy,
  input  logic                      eng_tgt_tx_busy,
  input  logic                      bus_tx_push,
  input  logic [DW-1:0]             bus_tx_data,
  input  logic                      bus_rx_pop,
  output logic [DW-1:0]             bus_rx_data,
  input  logic                      eng_tx_pop,
  output logic [DW-1:0]             eng_tx_data,
  input  logic                      eng_rx_push,
  input  logic [DW-1:0]             eng_rx_data,
  input  logic                      mask_wr,
  input  logic [6:0]                mask_wdata,
  input  logic                      clr_wr,
  input  logic [3:0]                clr_wdata,
  input  logic                      thr_wr,
  input  logic [$clog2(DEPTH)-1:0]  thr_wdata,
  output logic [$clog2(DEPTH):0]    tx_level,
  output logic [$clog2(DEPTH):0]    rx_level,
  output logic [5:0]                status,
  output logic [6:0]                raw_irq,
  output logic [6:0]                masked_irq,
  output logic [6:0]                irq_mask,
  output logic [$clog2(DEPTH)-1:0]  rx_thr,
  output logic                      irq
);
  logic    flush;
  logic    tx_full, tx_empty, rx_full, rx_empty;
  status_t st;

  assign flush = !ctl_en;

  spi_sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(bus_tx_push), .wr_data(bus_tx_data),
    .rd_en(eng_tx_pop), .rd_data(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(eng_rx_push), .wr_data(eng_rx_data),
    .rd_en(bus_rx_pop), .rd_data(bus_rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spi_irq_ctrl #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .tgt_mode(tgt_mode), .sel_n(sel_n),
    .tx_ovf_ev(ctl_en && bus_tx_push && tx_full),
    .rx_unf_ev(ctl_en && bus_rx_pop && rx_empty),
    .rx_ovf_ev(ctl_en && eng_rx_push && rx_full),
    .tx_empty(tx_empty), .rx_level(rx_level),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .thr_wr(thr_wr), .thr_wdata(thr_wdata),
    .raw_irq(raw_irq), .masked_irq(masked_irq), .irq_mask(irq_mask),
    .rx_thr(rx_thr), .irq(irq)
  );

  always_comb begin
    st.busy        = eng_busy || (ctl_en && !tx_empty);
    st.tx_full     = tx_full;
    st.tx_empty    = tx_empty;
    st.rx_empty    = rx_empty;
    st.rx_full     = rx_full;
    st.tgt_tx_busy = eng_tgt_tx_busy && tgt_mode;
  end
  assign status = st;
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      ctl_en,
  input logic                      bus_tx_push,
  input logic                      bus_rx_pop,
  input logic [DW-1:0]             bus_rx_data,
  input logic                      thr_wr,
  input logic [$clog2(DEPTH)-1:0]  rx_thr,
  input logic [$clog2(DEPTH):0]    tx_level,
  input logic [$clog2(DEPTH):0]    rx_level,
  input logic [6:0]                raw_irq,
  input logic [6:0]                irq_mask,
  input logic                      irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  // R4
  tx_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_en && bus_tx_push && (tx_level == LW'(DEPTH)) |=> raw_irq[1]);

  // R5
  rx_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_en && bus_rx_pop && (rx_level == '0) |=> (bus_rx_data == '0) && raw_irq[2]);

  // R7
  rx_level_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_level > LW'(rx_thr)) |-> raw_irq[4]);

  // R8
  thr_locked_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_en && thr_wr |=> $stable(rx_thr));

  // R10
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_mask != '0));

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> (tx_level == '0) && (rx_level == '0));
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.DW(DW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .ctl_en(ctl_en),
  .bus_tx_push(bus_tx_push), .bus_rx_pop(bus_rx_pop), .bus_rx_data(bus_rx_data),
  .thr_wr(thr_wr), .rx_thr(rx_thr), .tx_level(tx_level), .rx_level(rx_level),
  .raw_irq(raw_irq), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/spi_fifo_irq_unit_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_tb_top;
  localparam int DW = 16;
  localparam int DEPTH = 32;
  localparam int TW = $clog2(DEPTH);
  localparam int LW = TW + 1;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst, ctl_en, tgt_mode, sel_n, eng_busy, eng_tgt_tx_busy;
  logic bus_tx_push, bus_rx_pop, eng_tx_pop, eng_rx_push;
  logic [DW-1:0] bus_tx_data, eng_rx_data, bus_rx_data, eng_tx_data;
  logic mask_wr, clr_wr, thr_wr;
  logic [6:0] mask_wdata;
  logic [3:0] clr_wdata;
  logic [TW-1:0] thr_wdata, rx_thr;
  logic [LW-1:0] tx_level, rx_level;
  logic [5:0] status;
  logic [6:0] raw_irq, masked_irq, irq_mask;
  logic irq;

  spi_fifo_irq_unit #(.DW(DW), .DEPTH(DEPTH)) dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // op: 0 bus push tx, 1 engine push rx, 2 bus pop rx, 3 engine pop tx
  // fields: {op[1:0], data[15:0], expected data[15:0], tx level[7:0], rx level[7:0]}
  localparam logic [49:0] VEC [0:7] = '{
    {2'd0, 16'hA1A1, 16'h0000, 8'd1, 8'd0},
    {2'd0, 16'hB2B2, 16'h0000, 8'd2, 8'd0},
    {2'd3, 16'h0000, 16'hA1A1, 8'd1, 8'd0},
    {2'd3, 16'h0000, 16'hB2B2, 8'd0, 8'd0},
    {2'd1, 16'hC3C3, 16'h0000, 8'd0, 8'd1},
    {2'd1, 16'hD4D4, 16'h0000, 8'd0, 8'd2},
    {2'd2, 16'h0000, 16'hC3C3, 8'd0, 8'd1},
    {2'd2, 16'h0000, 16'hD4D4, 8'd0, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    bus_tx_push = 0; bus_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
    mask_wr = 0; clr_wr = 0; thr_wr = 0;
  endtask

  task automatic bus_push(input logic [DW-1:0] d);
    bus_tx_push = 1; bus_tx_data = d; tick(); idle();
  endtask

  task automatic eng_push(input logic [DW-1:0] d);
    eng_rx_push = 1; eng_rx_data = d; tick(); idle();
  endtask

  task automatic clr(input logic [3:0] c);
    clr_wr = 1; clr_wdata = c; tick(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; ctl_en = 0; tgt_mode = 0; sel_n = 1; eng_busy = 0; eng_tgt_tx_busy = 0;
    bus_tx_data = 0; eng_rx_data = 0; mask_wdata = 0; clr_wdata = 0; thr_wdata = 0;
    idle();
    @(negedge clk); tick(); tick();
    rst = 0; tick();

    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 raw", 32'(raw_irq), 32'h01);
    chk("R1 status", 32'(status), 32'h0C);
    chk("R1 mask/thr/irq", {irq_mask, 8'(rx_thr), 7'(irq)}, 0);

    // R8: threshold written while disabled is taken
    thr_wr = 1; thr_wdata = 3; tick(); idle();
    chk("R8 thr disabled", 32'(rx_thr), 3);
    ctl_en = 1; tick();
    thr_wr = 1; thr_wdata = 7; tick(); idle();
    chk("R8 thr enabled ignored", 32'(rx_thr), 3);

    // R2: vector table
    foreach (VEC[i]) begin
      logic [49:0] v;
      v = VEC[i];
      case (v[49:48])
        2'd0: begin bus_tx_push = 1; bus_tx_data = v[47:32]; end
        2'd1: begin eng_rx_push = 1; eng_rx_data = v[47:32]; end
        2'd2: bus_rx_pop = 1;
        default: eng_tx_pop = 1;
      endcase
      tick(); idle();
      if (v[49:48] == 2'd2) chk("R2 bus_rx_data", 32'(bus_rx_data), 32'(v[31:16]));
      if (v[49:48] == 2'd3) chk("R2 eng_tx_data", 32'(eng_tx_data), 32'(v[31:16]));
      chk("R2 tx_level", 32'(tx_level), 32'(v[15:8]));
      chk("R2 rx_level", 32'(rx_level), 32'(v[7:0]));
    end

    // R3 status layout
    bus_push(16'h0001);
    eng_tgt_tx_busy = 1; tick();
    chk("R3 status one word, not target", 32'(status), 32'h09);
    tgt_mode = 1; tick();
    chk("R3 status target busy", 32'(status), 32'h29);
    tgt_mode = 0; eng_tgt_tx_busy = 0;

    // R4 fill transmit queue, then overflow
    for (int k = 2; k <= DEPTH; k++) bus_push(16'(k));
    chk("R4 tx full level", 32'(tx_level), DEPTH);
    chk("R3 status full", 32'(status), 32'h0B);
    chk("R4 no ovf yet", 32'(raw_irq[1]), 0);
    bus_push(16'hFFFF);
    chk("R4 level kept", 32'(tx_level), DEPTH);
    chk("R4 ovf set", 32'(raw_irq[1]), 1);
    tick();
    chk("R4 ovf sticky", 32'(raw_irq[1]), 1);
    clr(4'b1000);
    chk("R9 clear tx ovf", 32'(raw_irq[1]), 0);

    // drain, check order end-to-end
    for (int k = 1; k <= DEPTH; k++) begin
      eng_tx_pop = 1; tick(); idle();
      if (k == DEPTH) chk("R2 last tx word", 32'(eng_tx_data), DEPTH);
    end
    chk("R7 tx empty raw", 32'(raw_irq[0]), 1);

    // R7 receive full-level with threshold 3
    for (int k = 0; k < 3; k++) eng_push(16'(k + 100));
    chk("R7 below threshold", 32'(raw_irq[4]), 0);
    eng_push(16'd103);
    chk("R7 at threshold+1", 32'(raw_irq[4]), 1);

    // R10 mask
    mask_wr = 1; mask_wdata = 7'h10; tick(); idle();
    chk("R10 masked", 32'(masked_irq), 32'h10);
    chk("R10 irq high", 32'(irq), 1);
    mask_wr = 1; mask_wdata = 7'h02; tick(); idle();
    chk("R10 irq low", 32'(irq), 0);

    // R6 receive overflow
    for (int k = 4; k < DEPTH; k++) eng_push(16'(k + 100));
    chk("R6 rx full", 32'(rx_level), DEPTH);
    eng_push(16'hEEEE);
    chk("R6 rx level kept", 32'(rx_level), DEPTH);
    chk("R6 ovf set", 32'(raw_irq[3]), 1);
    for (int k = 0; k < DEPTH; k++) begin
      bus_rx_pop = 1; tick(); idle();
      if (k == DEPTH - 1) chk("R6 last rx word not overwritten", 32'(bus_rx_data), 32'(DEPTH - 1 + 100));
    end

    // R5 underflow
    bus_rx_pop = 1; tick(); idle();
    chk("R5 zero data", 32'(bus_rx_data), 0);
    chk("R5 unf set", 32'(raw_irq[2]), 1);
    chk("R7 rx level off", 32'(raw_irq[4]), 0);

    // R9 selective clears
    clr(4'b0100);
    chk("R9 clear rx ovf", 32'(raw_irq[3:2]), 2'b01);

    // R12 select release
    sel_n = 0; tick(); sel_n = 1; tick();
    chk("R12 not target", 32'(raw_irq[6]), 0);
    tgt_mode = 1;
    sel_n = 0; tick(); sel_n = 1; tick();
    chk("R12 target release", 32'(raw_irq[6]), 1);
    tgt_mode = 0;

    clr(4'b0001);
    chk("R9 clear all", 32'(raw_irq), 32'h01);

    // R11 flush on disable
    bus_push(16'h1111); bus_push(16'h2222); eng_push(16'h3333);
    ctl_en = 0; tick();
    chk("R11 flushed tx", 32'(tx_level), 0);
    chk("R11 flushed rx", 32'(rx_level), 0);
    bus_push(16'h4444); eng_push(16'h5555);
    chk("R11 ignored while off", 32'({tx_level, rx_level}), 0);
    chk("R11 no ovf while off", 32'(raw_irq[3:1]), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule